// File: doc/BRIEF.md
# Predicated Tree-Reduction Index Scheduler

This block drives an in-place parallel tree reduction over a vector of up to 64 elements. A start strobe captures a vector length, a predicate mask and an operator. From then on the block issues one element pair per clock. Each pair names a lower element, which is the destination and the left operand, and a higher element, which is the right operand. Elements whose predicate bit is clear, or that lie at or beyond the vector length, are skipped entirely. They are never substituted with an identity value, and no copy steps are ever issued. Because of this, the reduced value ends up in the lowest-indexed active element, not in a fixed slot.

The reduction runs in rounds. At the start of each round, the current survivors are paired in ascending order: first with second, third with fourth, and so on. The higher member of each pair drops out. An unpaired last survivor carries over to the next round unchanged. Each round ends with one turnover clock that issues no pair. On that clock the block either reloads the next round or, when at most one survivor is left, raises done.

A small lane register file with an add/subtract unit is built in, so the schedule can be exercised end to end. It has a load port and a read port that work only while the scheduler is idle. The scheduler answers only to the 4-bit mode code 4'b0111.

Top module: `tree_reduce_sched`

## Requirements
- R1: A start is accepted only when `mode` equals 4'b0111 and `busy` is low. A start with any other mode, or a start while busy, changes neither the schedule nor the outputs.
- R2: Element i takes part only if i < `vlen` and `mask[i]` is 1. Other elements are never named in a step, and their register values are unchanged by a run.
- R3: In every round the survivors are paired in ascending index order. Each step has `step_dst` < `step_src`, both survivors, and `step_src` is retired from all later rounds.
- R4: Steps of one round come on consecutive clocks, starting the clock after the start is accepted. Every round is followed by exactly one clock with `step_valid` low.
- R5: When a round has an odd number of survivors, the highest one is not named in that round and survives into the next.
- R6: `done` is high for exactly one clock: the turnover clock on which at most one survivor remains. `busy` is low on the following clock. With zero or one active element, the first clock after the start is that clock, and no step is issued.
- R7: Each step writes `rf[dst] + rf[src]` (operator 0) or `rf[dst] - rf[src]` (operator 1) into `rf[dst]`, modulo 2^W. The operator is captured at start.
- R8: After done, the lowest active element holds the tree-ordered reduction of all active elements.
- R9: While `rst_n` is low and after reset, `busy`, `step_valid` and `done` are low.
- R10: `ld_en` writes `ld_data` into element `ld_idx` only while `busy` is low. `rd_data` shows element `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe |
| mode | input | 4 | Mode code; only 4'b0111 starts a reduction |
| vlen | input | 7 | Vector length, 0 to 64 |
| mask | input | 64 | Predicate, bit i enables element i |
| op_sub | input | 1 | Operator: 0 add, 1 subtract (left minus right) |
| ld_en | input | 1 | Element load enable (idle only) |
| ld_idx | input | 6 | Element to load |
| ld_data | input | 16 | Load value |
| rd_idx | input | 6 | Element to read |
| rd_data | output | 16 | Value of element `rd_idx` |
| busy | output | 1 | Reduction in progress |
| step_valid | output | 1 | A pair is issued this clock |
| step_dst | output | 6 | Destination / left-operand element |
| step_src | output | 6 | Right-operand element |
| done | output | 1 | Final turnover clock |

## Verification
A corrupted survivor or pending set shows at the ports on the very next clock. The pair it issues is wrong, or a turnover clock appears or goes missing, so a clock-by-clock comparison against a queue-based survivor model catches it at once. An operand-order or operator fault leaves the schedule intact but changes the value in the lowest active element. It is therefore caught when all 64 elements are read back after done, using subtraction with random masks and lengths. That same readback shows whether any masked element was touched.

// File: rtl/trs_pkg.sv
// Package: shared constants and types for the tree-reduction scheduler.
// Assumes: nothing; pure declarations.
package trs_pkg;
    // Mode code that selects the predicated tree reduction.
    localparam logic [3:0] TRS_MODE_TREE = 4'b0111;

    // Operator applied by the lane datapath.
    typedef enum logic {
        TRS_OP_ADD = 1'b0,
        TRS_OP_SUB = 1'b1
    } trs_op_e;
endpackage

// File: rtl/trs_lowbit.sv
// Module: trs_lowbit
// Finds the lowest set bit of a vector (priority encoder, bit 0 wins).
// Assumes: N is a power of two, at least 2.
module trs_lowbit #(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          hit
);
    // Scan from the top so the lowest set bit is the last assignment.
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/trs_sched.sv
// Module: trs_sched
// Round-based pair scheduler. It keeps the survivor set (live) and the
// survivors not yet paired in the current round (pend). One pair is
// issued per clock, followed by a turnover clock per round.
// Assumes: mask and vlen are sampled only on an accepted start.
module trs_sched
    import trs_pkg::*;
#(
    parameter int N = 64,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    mode,
    input  logic [IW:0]   vlen,
    input  logic [N-1:0]  mask,
    input  logic          op_sub,
    output logic          busy,
    output logic          step_valid,
    output logic [IW-1:0] step_dst,
    output logic [IW-1:0] step_src,
    output logic          done,
    output trs_op_e       op_sel
);
    logic [N-1:0] live_q, pend_q;
    logic [N-1:0] lane_ok, pend_rest, src_onehot;
    logic         busy_q, hit_a, hit_b, pair_ok, live_many, accept;
    trs_op_e      op_q;

    // Lanes inside the vector length.
    for (genvar g = 0; g < N; g++) begin : g_lane
        assign lane_ok[g] = (vlen > (IW + 1)'(g));
    end

    // Lowest pending survivor, then the next one above it.
    assign pend_rest = pend_q & (pend_q - N'(1));

    trs_lowbit #(.N(N)) u_pick_a (.vec(pend_q),    .idx(step_dst), .hit(hit_a));
    trs_lowbit #(.N(N)) u_pick_b (.vec(pend_rest), .idx(step_src), .hit(hit_b));

    // Decode the retired right operand and classify the round state.
    assign src_onehot = {{(N - 1){1'b0}}, 1'b1} << step_src;
    assign pair_ok    = hit_a & hit_b;
    assign live_many  = |(live_q & (live_q - N'(1)));
    assign accept     = start & ~busy_q & (mode == TRS_MODE_TREE);

    // Survivor, pending and run-state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            live_q <= '0;
            pend_q <= '0;
            op_q   <= TRS_OP_ADD;
        end else if (accept) begin
            busy_q <= 1'b1;
            live_q <= mask & lane_ok;
            pend_q <= mask & lane_ok;
            op_q   <= trs_op_e'(op_sub);
        end else if (busy_q) begin
            if (pair_ok) begin
                pend_q <= pend_rest & (pend_rest - N'(1));
                live_q <= live_q & ~src_onehot;
            end else if (live_many) begin
                pend_q <= live_q;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy       = busy_q;
    assign step_valid = busy_q & pair_ok;
    assign done       = busy_q & ~pair_ok & ~live_many;
    assign op_sel     = op_q;

    // R3
    dst_below_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (step_dst < step_src));

    // R3
    src_retired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> !live_q[$past(step_src)]);

    // R6
    done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R1
    bad_mode_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode != TRS_MODE_TREE) |=> !busy);

    // R5
    live_never_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($countones(live_q) <= $countones($past(live_q))));
endmodule

// File: rtl/trs_lanes.sv
// Module: trs_lanes
// Element register file with one add/subtract unit. A step writes the
// combined value back into the left (lower) element.
// Assumes: wr_en and ld_en are never high together; data is not reset.
module trs_lanes
    import trs_pkg::*;
#(
    parameter int N = 64,
    parameter int W = 16,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [IW-1:0] ld_idx,
    input  logic [W-1:0]  ld_data,
    input  logic          wr_en,
    input  logic [IW-1:0] a_idx,
    input  logic [IW-1:0] b_idx,
    input  trs_op_e       op,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] rf [N];
    logic [W-1:0] lhs, rhs, result;

    // Operand fetch and combine, left operand is the lower element.
    always_comb begin
        lhs    = rf[a_idx];
        rhs    = rf[b_idx];
        result = (op == TRS_OP_SUB) ? (lhs - rhs) : (lhs + rhs);
    end

    // Step writeback or idle-time load.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            rf[a_idx] <= result;
        end else if (ld_en) begin
            rf[ld_idx] <= ld_data;
        end
    end

    assign rd_data = rf[rd_idx];

    // R10
    ld_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_en && wr_en));
endmodule

// File: rtl/tree_reduce_sched.sv
// Module: tree_reduce_sched (top)
// Predicated tree-reduction scheduler with a built-in lane datapath.
// Assumes: loads are only meaningful while idle; they are gated here.
module tree_reduce_sched
    import trs_pkg::*;
#(
    parameter int N = 64,
    parameter int W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [3:0]           mode,
    input  logic [$clog2(N):0]   vlen,
    input  logic [N-1:0]         mask,
    input  logic                 op_sub,
    input  logic                 ld_en,
    input  logic [$clog2(N)-1:0] ld_idx,
    input  logic [W-1:0]         ld_data,
    input  logic [$clog2(N)-1:0] rd_idx,
    output logic [W-1:0]         rd_data,
    output logic                 busy,
    output logic                 step_valid,
    output logic [$clog2(N)-1:0] step_dst,
    output logic [$clog2(N)-1:0] step_src,
    output logic                 done
);
    trs_op_e op_sel;
    logic    ld_gate;

    // Loads only while no reduction is running.
    assign ld_gate = ld_en & ~busy;

    trs_sched #(.N(N)) u_sched (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .vlen(vlen), .mask(mask), .op_sub(op_sub),
        .busy(busy), .step_valid(step_valid), .step_dst(step_dst),
        .step_src(step_src), .done(done), .op_sel(op_sel)
    );

    trs_lanes #(.N(N), .W(W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_gate), .ld_idx(ld_idx),
        .ld_data(ld_data), .wr_en(step_valid), .a_idx(step_dst),
        .b_idx(step_src), .op(op_sel), .rd_idx(rd_idx), .rd_data(rd_data)
    );
endmodule

// File: tb/tree_reduce_sched_tb.sv
module tree_reduce_sched_tb;
    localparam int N = 64;
    localparam int W = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = 4'd0;
    logic [6:0]    vlen = '0;
    logic [N-1:0]  mask = '0;
    logic          op_sub = 1'b0;
    logic          ld_en = 1'b0;
    logic [5:0]    ld_idx = '0;
    logic [W-1:0]  ld_data = '0;
    logic [5:0]    rd_idx = '0;
    logic [W-1:0]  rd_data;
    logic          busy, step_valid, done;
    logic [5:0]    step_dst, step_src;

    always #10 clk = ~clk;

    tree_reduce_sched #(.N(N), .W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .vlen(vlen),
        .mask(mask), .op_sub(op_sub), .ld_en(ld_en), .ld_idx(ld_idx),
        .ld_data(ld_data), .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy),
        .step_valid(step_valid), .step_dst(step_dst), .step_src(step_src),
        .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [W-1:0] model [N];

    typedef struct { bit v; bit dn; int d; int s; } item_t;
    item_t exp_q[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Watchdog: a hung run is a failed check, then the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic load_all();
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 6'(i); ld_data = W'($urandom);
            model[i] = ld_data;
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Behavioural survivor-queue model: expected steps and final values.
    task automatic build(input int vl, input logic [N-1:0] m, input bit sub);
        int live[$];
        int nxt[$];
        item_t it;
        exp_q.delete();
        for (int i = 0; i < N; i++) if (i < vl && m[i]) live.push_back(i);
        forever begin
            nxt.delete();
            for (int k = 0; k + 1 < live.size(); k += 2) begin
                it.v = 1; it.dn = 0; it.d = live[k]; it.s = live[k+1];
                exp_q.push_back(it);
                model[it.d] = sub ? model[it.d] - model[it.s] : model[it.d] + model[it.s];
                nxt.push_back(live[k]);
            end
            if (live.size() % 2 == 1) nxt.push_back(live[live.size()-1]);
            it.v = 0; it.dn = (nxt.size() <= 1); it.d = 0; it.s = 0;
            exp_q.push_back(it);
            live = nxt;
            if (it.dn) break;
        end
    endtask

    task automatic run(input int vl, input logic [N-1:0] m, input bit sub, input bit poke);
        logic [W-1:0] keep0;
        int low = -1;
        load_all();
        for (int i = N - 1; i >= 0; i--) if (i < vl && m[i]) low = i;
        build(vl, m, sub);
        keep0 = model[0];
        @(negedge clk);
        start = 1'b1; mode = 4'b0111; vlen = 7'(vl); mask = m; op_sub = sub;
        for (int k = 0; k < exp_q.size(); k++) begin
            @(negedge clk);
            start = 1'b0; ld_en = 1'b0;
            chk(busy == 1'b1, "R1", "busy during run", busy, 1);
            chk(step_valid == exp_q[k].v, "R4", "step_valid", step_valid, exp_q[k].v);
            chk(done == exp_q[k].dn, "R6", "done", done, exp_q[k].dn);
            if (exp_q[k].v) begin
                chk(step_dst == exp_q[k].d, "R3", "step_dst", step_dst, exp_q[k].d);
                chk(step_src == exp_q[k].s, "R5", "step_src", step_src, exp_q[k].s);
            end
            if (poke && k == 1) begin
                // R1 start while busy, R10 load while busy: both ignored
                start = 1'b1; mask = ~m; ld_en = 1'b1; ld_idx = 6'd0;
                ld_data = keep0 ^ 16'h5a5a;
            end
        end
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0;
        chk(busy == 1'b0, "R6", "busy after done", busy, 0);
        chk(step_valid == 1'b0, "R6", "valid after done", step_valid, 0);
        for (int i = 0; i < N; i++) begin
            rd_idx = 6'(i);
            #1;
            if (i == low)
                chk(rd_data == model[i], "R8", "result lane", rd_data, model[i]);
            else if (i < vl && m[i])
                chk(rd_data == model[i], "R7", "inner lane", rd_data, model[i]);
            else
                chk(rd_data == model[i], "R2/R10", "masked lane", rd_data, model[i]);
        end
    endtask

    initial begin
        logic [N-1:0] rm;
        repeat (3) @(negedge clk);
        // R9 outputs quiet in reset
        chk(busy == 1'b0, "R9", "busy in reset", busy, 0);
        chk(step_valid == 1'b0, "R9", "valid in reset", step_valid, 0);
        chk(done == 1'b0, "R9", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R9", "busy after reset", busy, 0);

        // R1 wrong mode code is ignored
        @(negedge clk);
        start = 1'b1; mode = 4'b0101; vlen = 7'd64; mask = '1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R1", "busy after bad mode", busy, 0);
        chk(step_valid == 1'b0, "R1", "valid after bad mode", step_valid, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy later", busy, 0);

        run(8, 64'hF0, 1'b0, 1'b0);          // worked 8-element case
        run(8, 64'hF0, 1'b1, 1'b0);          // same, subtract
        run(64, 64'h0, 1'b0, 1'b0);          // no active lane (R6)
        run(64, 64'h0000_0100_0000_0000, 1'b1, 1'b0); // single lane (R6)
        run(0, '1, 1'b0, 1'b0);              // zero length (R2)
        run(5, '1, 1'b1, 1'b0);              // length cuts mask (R2)
        run(7, 64'h7F, 1'b1, 1'b0);          // odd survivors (R5)
        run(64, '1, 1'b0, 1'b0);             // full vector
        run(64, '1, 1'b1, 1'b1);             // full, with ignored poke
        for (int t = 0; t < 24; t++) begin
            rm = {$urandom, $urandom};
            if (t % 3 == 0) rm = rm & {$urandom, $urandom};
            run(($urandom % 64) + 1, rm, 1'(t), 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule